// File: doc/BRIEF.md
# Nested Prioritized Interrupt Controller

This block gathers level-sensitive interrupt lines from a configurable number of peripheral sources. The default is 82 sources and the maximum is 240. For each source it keeps an enable bit, a pending bit, an active bit and a 4-bit urgency value. From these it offers the CPU one request: the most urgent source that is enabled and pending, provided that source can preempt the work already under way.

Software reaches the bits over a small word-addressed register port. Enables and pending bits each have one word bank for setting and another for clearing. The CPU answers a request with a take pulse, which moves the source from pending to active. It ends a handler with a return pulse. An internal nesting stack records the order in which sources were taken, so each return closes the innermost handler.

Top module: `irq_nest_ctrl`

## Requirements
- R1: Enable bits are written through the set-enable words at address 0x00+k and the clear-enable words at 0x08+k. Word k holds IRQ n at bit n mod 32, with k = n div 32. A 1 in the written data sets (or clears) that enable, and a 0 leaves it unchanged. Reading either word returns the current enables. Bits for IRQ numbers that do not exist read 0.
- R2: Pending bits are written through the set-pending words at 0x10+k and the clear-pending words at 0x18+k, with the same write-1 rule and read-back as R1. Any clock edge that sees an input line high sets that line's pending bit. The clear-pending write wins over the input during its own cycle.
- R3: Urgency values are packed four to a word at 0x40+w, one byte per source, with w = n div 4 and byte lane n mod 4. Only bits 7:4 of each byte are stored. Bits 3:0 read 0, and lanes for IRQ numbers that do not exist read 0.
- R4: The offered IRQ number is the enabled and pending source with the smallest urgency value, where 0 is the most urgent. When two such sources have equal values, the lower IRQ number wins.
- R5: `cpu_req` is high only when the offered value is strictly smaller than the current execution level. The execution level is the smallest value over all active sources, or 16 when no source is active.
- R6: While `mask_all` is high, `cpu_req` stays low.
- R7: A `cpu_ack` pulse given while `cpu_req` is high clears the offered source's pending bit and sets its active bit in the same clock edge. An ack given while `cpu_req` is low has no effect. The active words at 0x20+k are read-only.
- R8: A `cpu_ret` pulse clears the active bit of the most recently taken source that is still active. A return with no active source is ignored. When `cpu_ret` and `cpu_ack` arrive in the same cycle, the ack is ignored.
- R9: A source whose line is high while it is active becomes active and pending. It does not preempt itself, and it is offered again after its return.
- R10: After reset, all enables, pending bits, active bits and urgency values are 0, and `cpu_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NSRC | Level request lines, one per source |
| mask_all | input | 1 | Global block of all requests |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 7 | Register word address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational from the address |
| cpu_req | output | 1 | Request to the CPU |
| cpu_irq_num | output | $clog2(NSRC) | IRQ number of the offered source |
| cpu_ack | input | 1 | CPU takes the offered source |
| cpu_ret | input | 1 | CPU returns from the innermost handler |

## Verification
Faults in the nesting stack are the hardest to see. If the stack pointer or a stack entry goes wrong, the wrong active bit is cleared on a return. That shows up in the active words one cycle after the return. It also shows up on `cpu_req`, which either fails to rise for a source that should now preempt or rises for one that should stay blocked.

A wrong pending update is visible on the pending read-back one edge after a take. For a held line it is visible one edge later still, when the bit should have come back. Arbitration faults appear directly on `cpu_irq_num` at the next read after any enable, pending or urgency change. The tests are built so that equal-urgency ties, strict preemption and return order each produce a distinct port value.

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl #(
  parameter int NSRC = 82,
  parameter int PW   = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NSRC-1:0]         irq_in,
  input  logic                    mask_all,
  input  logic                    bus_we,
  input  logic [6:0]              bus_addr,
  input  logic [31:0]             bus_wdata,
  output logic [31:0]             bus_rdata,
  output logic                    cpu_req,
  output logic [$clog2(NSRC)-1:0] cpu_irq_num,
  input  logic                    cpu_ack,
  input  logic                    cpu_ret
);
  localparam int IW    = $clog2(NSRC);
  localparam int DEPTH = 1 << PW;
  localparam int SPW   = PW + 1;
  localparam int LSB   = 8 - PW;

  logic [NSRC-1:0] en, pend, act;
  logic [PW-1:0]   prio [NSRC];
  logic [IW-1:0]   stk  [DEPTH];
  logic [SPW-1:0]  sp;

  wire       is_prio = bus_addr[6];
  wire [2:0] bank    = bus_addr[5:3];
  wire [2:0] wsel    = bus_addr[2:0];

  logic [NSRC-1:0] set_en, clr_en, set_pd, clr_pd;
  always_comb begin
    for (int i = 0; i < NSRC; i++) begin
      logic hit;
      hit = bus_we && !is_prio && (wsel == 3'(i / 32)) && bus_wdata[i % 32];
      set_en[i] = hit && (bank == 3'd0);
      clr_en[i] = hit && (bank == 3'd1);
      set_pd[i] = hit && (bank == 3'd2);
      clr_pd[i] = hit && (bank == 3'd3);
    end
  end

  logic [PW:0]   best_p, exec_p;
  logic [IW-1:0] best_i;
  always_comb begin
    best_p = (PW+1)'(DEPTH);
    exec_p = (PW+1)'(DEPTH);
    best_i = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (en[i] && pend[i] && ({1'b0, prio[i]} < best_p)) begin
        best_p = {1'b0, prio[i]};
        best_i = IW'(i);
      end
      if (act[i] && ({1'b0, prio[i]} < exec_p)) exec_p = {1'b0, prio[i]};
    end
  end

  assign cpu_req     = !mask_all && (best_p < exec_p);
  assign cpu_irq_num = best_i;

  wire           take   = cpu_ack && cpu_req && !cpu_ret;
  wire           pop    = cpu_ret && (sp != '0);
  wire [PW-1:0]  top    = PW'(sp - 1'b1);
  wire [NSRC-1:0] ack_oh = take ? (NSRC'(1) << best_i) : '0;
  wire [NSRC-1:0] pop_oh = pop  ? (NSRC'(1) << stk[top]) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en   <= '0;
      pend <= '0;
      act  <= '0;
      sp   <= '0;
      for (int i = 0; i < NSRC; i++) prio[i] <= '0;
    end else begin
      en   <= (en | set_en) & ~clr_en;
      pend <= (pend | irq_in | set_pd) & ~clr_pd & ~ack_oh;
      act  <= (act | ack_oh) & ~pop_oh;
      if (pop)       sp <= sp - 1'b1;
      else if (take) sp <= sp + 1'b1;
      for (int i = 0; i < NSRC; i++)
        if (bus_we && is_prio && (bus_addr[5:0] == 6'(i / 4)))
          prio[i] <= bus_wdata[8*(i%4)+LSB +: PW];
    end
  end

  always_ff @(posedge clk)
    if (take) stk[PW'(sp)] <= best_i;

  wire [255:0] en_pad   = 256'(en);
  wire [255:0] pend_pad = 256'(pend);
  wire [255:0] act_pad  = 256'(act);

  always_comb begin
    bus_rdata = '0;
    if (is_prio) begin
      for (int i = 0; i < NSRC; i++)
        if (bus_addr[5:0] == 6'(i / 4)) bus_rdata[8*(i%4)+LSB +: PW] = prio[i];
    end else begin
      case (bank)
        3'd0, 3'd1: bus_rdata = en_pad[{wsel, 5'b0} +: 32];
        3'd2, 3'd3: bus_rdata = pend_pad[{wsel, 5'b0} +: 32];
        3'd4:       bus_rdata = act_pad[{wsel, 5'b0} +: 32];
        default:    bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/irq_nest_chk.sv
module irq_nest_chk #(
  parameter int NSRC = 82,
  parameter int PW   = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    mask_all,
  input logic                    cpu_req,
  input logic [$clog2(NSRC)-1:0] cpu_irq_num,
  input logic                    cpu_ack,
  input logic                    cpu_ret,
  input logic [NSRC-1:0]         en,
  input logic [NSRC-1:0]         pend,
  input logic [NSRC-1:0]         act,
  input logic [PW:0]             sp
);
  p_mask_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mask_all |-> !cpu_req);

  p_offer_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req |-> (en[cpu_irq_num] && pend[cpu_irq_num]));

  p_take_moves_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ack && cpu_req && !cpu_ret) |=> (act[$past(cpu_irq_num)] && !pend[$past(cpu_irq_num)]));

  p_stack_matches_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(act) == int'(sp));

  p_return_pops_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ret && $countones(act) != 0) |=> ($countones(act) == $past($countones(act)) - 1));
endmodule

bind irq_nest_ctrl irq_nest_chk #(.NSRC(NSRC), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mask_all(mask_all), .cpu_req(cpu_req),
  .cpu_irq_num(cpu_irq_num), .cpu_ack(cpu_ack), .cpu_ret(cpu_ret),
  .en(en), .pend(pend), .act(act), .sp(sp));

// File: tb/tb_irq_nest_ctrl.sv
module tb_irq_nest_ctrl;
  localparam int NSRC = 82;
  localparam int IW   = $clog2(NSRC);

  logic clk = 0, rst_n = 0;
  logic [NSRC-1:0] irq_in = '0;
  logic mask_all = 0, bus_we = 0, cpu_ack = 0, cpu_ret = 0;
  logic [6:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic cpu_req;
  logic [IW-1:0] cpu_irq_num;
  int total = 0, fails = 0;

  always #2 clk = ~clk;

  irq_nest_ctrl #(.NSRC(NSRC)) dut (.*);

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [6:0] a, logic [31:0] d);
    @(negedge clk); bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic rd(logic [6:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; #1 d = bus_rdata;
  endtask

  task automatic pulse(logic a, logic r);
    @(negedge clk); cpu_ack = a; cpu_ret = r;
    @(negedge clk); cpu_ack = 0; cpu_ret = 0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(7'h00, d); chk("R10 enable", d, 0);
    rd(7'h10, d); chk("R10 pending", d, 0);
    rd(7'h40, d); chk("R10 prio", d, 0);
    chk("R10 req", {31'b0, cpu_req}, 0);
  endtask

  task automatic t_enable();
    logic [31:0] d;
    wr(7'h00, 32'h5);
    rd(7'h00, d); chk("R1 set", d, 32'h5);
    rd(7'h08, d); chk("R1 read via clear word", d, 32'h5);
    wr(7'h08, 32'h4);
    rd(7'h00, d); chk("R1 clear", d, 32'h1);
    wr(7'h00, 32'h0);
    rd(7'h00, d); chk("R1 zero write", d, 32'h1);
    wr(7'h02, 32'h0006_0000);
    rd(7'h02, d); chk("R1 last word", d, 32'h0002_0000);
    wr(7'h08, 32'hFFFF_FFFF); wr(7'h0A, 32'hFFFF_FFFF);
    rd(7'h02, d); chk("R1 cleared", d, 0);
  endtask

  task automatic t_prio();
    logic [31:0] d;
    wr(7'h40, 32'hFFFF_FFFF);
    rd(7'h40, d); chk("R3 nibble", d, 32'hF0F0_F0F0);
    wr(7'h54, 32'hFFFF_FFFF);
    rd(7'h54, d); chk("R3 last word", d, 32'h0000_F0F0);
    wr(7'h40, 32'h0);
  endtask

  task automatic t_arbitrate();
    logic [31:0] d;
    wr(7'h40, 32'h2000_0000);
    wr(7'h41, 32'h0000_2000);
    wr(7'h00, 32'h0000_0028);
    wr(7'h01, 32'h0000_0100);
    wr(7'h10, 32'h0000_00A8);
    rd(7'h10, d); chk("R2 set pending", d, 32'hA8);
    @(negedge clk);
    chk("R4 tie lower number", {31'b0, cpu_req, 24'b0, 8'(cpu_irq_num)} >> 0,
        {31'b0, 1'b1, 24'b0, 8'd3});
    wr(7'h4A, 32'h0000_0010);
    wr(7'h11, 32'h0000_0100);
    @(negedge clk);
    chk("R4 more urgent", 32'(cpu_irq_num), 40);
    mask_all = 1;
    @(negedge clk);
    chk("R6 masked", {31'b0, cpu_req}, 0);
    pulse(1, 0);
    rd(7'h21, d); chk("R7 ack ignored without req", d, 0);
    mask_all = 0;
  endtask

  task automatic t_nest();
    logic [31:0] d;
    pulse(1, 0);
    rd(7'h21, d); chk("R7 active set", d, 32'h100);
    rd(7'h11, d); chk("R7 pending cleared", d, 0);
    wr(7'h21, 32'h0);
    rd(7'h21, d); chk("R7 active read-only", d, 32'h100);
    chk("R5 no preempt by less urgent", {31'b0, cpu_req}, 0);
    wr(7'h41, 32'h0);
    @(negedge clk);
    chk("R5 preempt", {31'b0, cpu_req, 24'b0, 8'(cpu_irq_num)}, {31'b0, 1'b1, 24'b0, 8'd5});
    pulse(1, 0);
    rd(7'h20, d); chk("R7 nested active", d, 32'h20);
    pulse(0, 1);
    rd(7'h20, d); chk("R8 inner popped", d, 0);
    rd(7'h21, d); chk("R8 outer kept", d, 32'h100);
    chk("R5 still blocked", {31'b0, cpu_req}, 0);
    pulse(0, 1);
    rd(7'h21, d); chk("R8 outer popped", d, 0);
    chk("R5 idle offers", {31'b0, cpu_req, 24'b0, 8'(cpu_irq_num)}, {31'b0, 1'b1, 24'b0, 8'd3});
    wr(7'h18, 32'hFFFF_FFFF); wr(7'h08, 32'hFFFF_FFFF); wr(7'h09, 32'hFFFF_FFFF);
    rd(7'h10, d); chk("R2 clear pending", d, 0);
  endtask

  task automatic t_repeat();
    logic [31:0] d;
    wr(7'h42, 32'h0030_0000);
    wr(7'h00, 32'h0000_0400);
    @(negedge clk); irq_in[10] = 1;
    @(negedge clk);
    chk("R2 line sets pending", {31'b0, cpu_req, 24'b0, 8'(cpu_irq_num)}, {31'b0, 1'b1, 24'b0, 8'd10});
    pulse(1, 0);
    rd(7'h10, d); chk("R9 pending again", d, 32'h400);
    rd(7'h20, d); chk("R9 active", d, 32'h400);
    chk("R9 no self preempt", {31'b0, cpu_req}, 0);
    irq_in[10] = 0;
    pulse(0, 1);
    chk("R9 offered after return", {31'b0, cpu_req, 24'b0, 8'(cpu_irq_num)}, {31'b0, 1'b1, 24'b0, 8'd10});
    pulse(1, 1);
    rd(7'h20, d); chk("R8 ret beats ack", d, 0);
    chk("R8 req remains", {31'b0, cpu_req}, 1);
    wr(7'h18, 32'h400);
    rd(7'h10, d); chk("R2 cleared", d, 0);
  endtask

  initial begin
    #(200000 * 4);
    fails++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_enable();
    t_prio();
    t_arbitrate();
    t_nest();
    t_repeat();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule